// File: doc/BRIEF.md
# Frame Phase Error Detector

This block measures how far a local receive frame sync has drifted from the frame pulse of a master line channel. Both events are single-cycle pulses on the fast clock and come once per frame period. The offset is quantized in gate units. A gate unit is one enable produced by a free-running divider on the fast clock, whose ratio is set by a run-time divider input. The result is a signed count: positive when the local sync trails the master frame, negative when it leads.

Every master frame pulse produces one report. That report carries the measurement belonging to the previous master frame. A local sync that arrives after a master pulse can only be measured once it shows up, so results are reported one frame late. A pairing that spans more than 511 units, or a frame with no local sync at all, counts as out of range. An out-of-range report raises a reinitialize flag together with the report. A mode input selects what the error output shows in that case: either zero, which realigns the loop to the next frame, or the last in-range value.

Top module: `frame_phase_detector`

## Requirements
- R1: One gate enable occurs every max(div_val,1) fast cycles, free-running from reset; the first is in cycle div_val-1 after reset release. An error magnitude is the number of gate enables in the cycles strictly between the two pulse cycles, so a div_val of 0 behaves as 1.
- R2: phase_err is a 10-bit two's-complement value: negative when the local sync precedes the master pulse, positive when it follows.
- R3: err_valid is a one-cycle pulse in the cycle after each sampled master pulse, and in no other cycle; reinit is high only together with err_valid.
- R4: The report issued at a master pulse gives the measurement of the previous master frame. phase_err keeps its value between reports.
- R5: A local sync in the same cycle as the master pulse, or with no gate enable between the two, measures zero.
- R6: A magnitude of 511 is reported as in range. A magnitude of 512 or more, or a frame with no local sync, is out of range; so is a leading local sync that aged past 511 units before the master pulse.
- R7: With reinit_mode=0 at the master pulse, an out-of-range report sets reinit=1 and phase_err=0.
- R8: With reinit_mode=1 at the master pulse, an out-of-range report sets reinit=1 and leaves phase_err at its previous value.
- R9: Reset clears phase_err, err_valid and reinit. The first report after reset is out of range.
- R10: A master pulse arriving while the previous frame is still waiting for a trailing local sync closes that frame as out of range.
- R11: When several local syncs precede one master pulse, only the latest one is measured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | DIV_W | Fast cycles per gate unit (0 treated as 1) |
| reinit_mode | input | 1 | Out-of-range policy: 0 report zero, 1 hold last value |
| loc_sync | input | 1 | Local receive frame sync pulse |
| mst_frame | input | 1 | Master channel frame pulse |
| phase_err | output | ERR_W | Signed phase error in gate units |
| err_valid | output | 1 | One-cycle report strobe |
| reinit | output | 1 | Out-of-range flag, valid with err_valid |

## Verification
The hardest points to reach are the exact window edges: 511 against 512 units on both sides of the master pulse, and at a divider above one, where a single fast cycle decides whether a gate enable falls inside the interval. The stimulus places every pulse on an absolute cycle index counted from reset release. The bench works out the expected unit count by enumerating gate-enable cycles, and at divider 3 it picks offsets that land on 511 and 513 units. A master pulse placed about 100 cycles after one with no local sync drives the still-open trailing window into the forced-close path. A stray early local sync before a closer one exercises the latest-wins rule.

// File: rtl/frame_phase_pkg.sv
package frame_phase_pkg;
  // Policy applied when a report is out of range
  typedef enum logic {
    OOR_REALIGN = 1'b0,
    OOR_HOLD    = 1'b1
  } oor_mode_e;
endpackage

// File: rtl/fpd_gate_div.sv
module fpd_gate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_c;

  always_comb last_c = (div_val == '0) ? '0 : div_val - 1'b1;

  // >= keeps the counter bounded if div_val shrinks at run time
  assign tick = (cnt_q >= last_c);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fpd_age_ctr.sv
module fpd_age_ctr #(
  parameter int LIMIT = 511,
  parameter int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             tick,
  output logic             active,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

  // start wins over stop; an event in the same cycle wins over expiry
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      count  <= '0;
    end else if (start) begin
      active <= 1'b1;
      count  <= '0;
    end else if (stop) begin
      active <= 1'b0;
    end else if (active && tick) begin
      if (count == LIM_C) active <= 1'b0;
      else                count  <= count + 1'b1;
    end
  end
endmodule

// File: rtl/fpd_report.sv
module fpd_report
  import frame_phase_pkg::*;
#(
  parameter int ERR_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    capture,
  input  oor_mode_e               mode,
  input  logic                    held_oor,
  input  logic signed [ERR_W-1:0] held_val,
  output logic signed [ERR_W-1:0] phase_err,
  output logic                    err_valid,
  output logic                    reinit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_err <= '0;
      err_valid <= 1'b0;
      reinit    <= 1'b0;
    end else begin
      err_valid <= capture;
      reinit    <= capture & held_oor;
      if (capture) begin
        if (!held_oor)                phase_err <= held_val;
        else if (mode == OOR_REALIGN) phase_err <= '0;
      end
    end
  end
endmodule

// File: rtl/frame_phase_detector.sv
module frame_phase_detector
  import frame_phase_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int RANGE_LIM = 511,
  parameter int ERR_W     = $clog2(RANGE_LIM + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DIV_W-1:0]        div_val,
  input  logic                    reinit_mode,
  input  logic                    loc_sync,
  input  logic                    mst_frame,
  output logic signed [ERR_W-1:0] phase_err,
  output logic                    err_valid,
  output logic                    reinit
);
  localparam int CNT_W = ERR_W - 1;

  logic             gate_tick;
  logic             lead_active, lag_active;
  logic [CNT_W-1:0] lead_cnt, lag_cnt;
  logic             lead_start, lag_start;
  logic             held_oor;
  logic signed [ERR_W-1:0] held_val;

  fpd_gate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div_val(div_val), .tick(gate_tick)
  );

  // Leading local sync waiting for a master pulse; a newer one restarts it
  assign lead_start = loc_sync & ~mst_frame & ~lag_active;
  fpd_age_ctr #(.LIMIT(RANGE_LIM), .CNT_W(CNT_W)) u_lead (
    .clk(clk), .rst(rst), .start(lead_start), .stop(mst_frame),
    .tick(gate_tick), .active(lead_active), .count(lead_cnt)
  );

  // Window after a master pulse that found no leading local sync
  assign lag_start = mst_frame & ~loc_sync & ~lead_active;
  fpd_age_ctr #(.LIMIT(RANGE_LIM), .CNT_W(CNT_W)) u_lag (
    .clk(clk), .rst(rst), .start(lag_start), .stop(loc_sync),
    .tick(gate_tick), .active(lag_active), .count(lag_cnt)
  );

  // Measurement of the current frame, reported at the next master pulse.
  // Opening a window parks an out-of-range result that a trailing sync overwrites.
  always_ff @(posedge clk) begin
    if (rst) begin
      held_oor <= 1'b1;
      held_val <= '0;
    end else if (mst_frame) begin
      if (loc_sync) begin
        held_oor <= 1'b0;
        held_val <= '0;
      end else if (lead_active) begin
        held_oor <= 1'b0;
        held_val <= -$signed({1'b0, lead_cnt});
      end else begin
        held_oor <= 1'b1;
      end
    end else if (loc_sync && lag_active) begin
      held_oor <= 1'b0;
      held_val <= $signed({1'b0, lag_cnt});
    end
  end

  fpd_report #(.ERR_W(ERR_W)) u_rep (
    .clk(clk), .rst(rst), .capture(mst_frame),
    .mode(oor_mode_e'(reinit_mode)),
    .held_oor(held_oor), .held_val(held_val),
    .phase_err(phase_err), .err_valid(err_valid), .reinit(reinit)
  );
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker #(
  parameter int DIV_W = 8,
  parameter int ERR_W = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic [DIV_W-1:0]        div_val,
  input logic                    reinit_mode,
  input logic                    loc_sync,
  input logic                    mst_frame,
  input logic signed [ERR_W-1:0] phase_err,
  input logic                    err_valid,
  input logic                    reinit
);
  localparam logic [ERR_W-1:0] MOST_NEG = {1'b1, {(ERR_W-1){1'b0}}};

  a_r3_valid_follows_master: assert property (@(posedge clk) disable iff (rst)
    mst_frame |=> err_valid);
  a_r3_valid_has_cause: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $past(mst_frame));
  a_r3_reinit_with_valid: assert property (@(posedge clk) disable iff (rst)
    reinit |-> err_valid);
  a_r7_realign_zero: assert property (@(posedge clk) disable iff (rst)
    (reinit && !$past(reinit_mode)) |-> (phase_err == '0));
  a_r8_hold_last: assert property (@(posedge clk) disable iff (rst)
    (reinit && $past(reinit_mode)) |-> $stable(phase_err));
  a_r6_in_range: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !reinit) |-> (phase_err != MOST_NEG));
  a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
    !err_valid |-> $stable(phase_err));
endmodule

bind frame_phase_detector fpd_checker #(.DIV_W(DIV_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .div_val(div_val), .reinit_mode(reinit_mode),
  .loc_sync(loc_sync), .mst_frame(mst_frame), .phase_err(phase_err),
  .err_valid(err_valid), .reinit(reinit)
);

// File: tb/frame_phase_detector_test.sv
module frame_phase_detector_test;
  localparam int DIV_W = 8;
  localparam int ERR_W = 10;
  localparam int LIM   = 511;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [DIV_W-1:0] div_val = '0;
  logic reinit_mode = 1'b0, loc_sync = 1'b0, mst_frame = 1'b0;
  logic signed [ERR_W-1:0] phase_err;
  logic err_valid, reinit;

  frame_phase_detector uut (
    .clk(clk), .rst(rst), .div_val(div_val), .reinit_mode(reinit_mode),
    .loc_sync(loc_sync), .mst_frame(mst_frame), .phase_err(phase_err),
    .err_valid(err_valid), .reinit(reinit)
  );

  int checks = 0, fails = 0, cyc = 0, dval = 1;
  int q_err[$];
  bit q_re[$];
  string q_tag[$];
  bit prev_oor = 1'b1;
  int prev_meas = 0, last_good = 0;
  bit prev_valid = 1'b0;

  always @(posedge clk) begin
    if (rst) cyc = 0;
    else     cyc = cyc + 1;
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // R1: gate enables strictly between cycles a and b
  function automatic int ticks(int a, int b);
    int n = 0;
    for (int t = a + 1; t < b; t++) if (t % dval == dval - 1) n++;
    return n;
  endfunction

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_reset(int d);
    @(negedge clk);
    rst = 1'b1; div_val = DIV_W'(d); loc_sync = 1'b0; mst_frame = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    dval = (d == 0) ? 1 : d;
    prev_oor = 1'b1; prev_meas = 0; last_good = 0;
    check(phase_err == 0, "R9 reset phase_err", int'(phase_err), 0);
    check(err_valid == 1'b0, "R9 reset err_valid", int'(err_valid), 0);
    check(reinit == 1'b0, "R9 reset reinit", int'(reinit), 0);
  endtask

  task automatic pulse_loc(int c);
    wait_cyc(c);
    loc_sync = 1'b1;
    @(negedge clk);
    loc_sync = 1'b0;
  endtask

  // Driver: pushes the expected report for this master pulse, then pulses it
  task automatic master_at(int c, bit with_loc, string tag);
    int e;
    bit re;
    wait_cyc(c);
    if (prev_oor) begin
      re = 1'b1;
      e  = reinit_mode ? last_good : 0;
    end else begin
      re = 1'b0;
      e  = prev_meas;
    end
    last_good = e;
    q_err.push_back(e); q_re.push_back(re); q_tag.push_back(tag);
    mst_frame = 1'b1; loc_sync = with_loc;
    @(negedge clk);
    mst_frame = 1'b0; loc_sync = 1'b0;
  endtask

  // off = local cycle - master cycle; tag names what this report checks
  task automatic frame(int m, int off, bit has_l, string tag);
    int k;
    if (has_l && off < 0) pulse_loc(m + off);
    master_at(m, has_l && off == 0, tag);
    if (has_l && off > 0) pulse_loc(m + off);
    if (!has_l) prev_oor = 1'b1;
    else if (off == 0) begin prev_oor = 1'b0; prev_meas = 0; end
    else if (off < 0) begin
      k = ticks(m + off, m); prev_oor = (k > LIM); prev_meas = -k;
    end else begin
      k = ticks(m, m + off); prev_oor = (k > LIM); prev_meas = k;
    end
  endtask

  // Monitor: pops the scoreboard on every report
  always @(negedge clk) begin
    if (rst) prev_valid = 1'b0;
    else begin
      if (reinit && !err_valid) check(1'b0, "R3 reinit without strobe", 1, 0);
      if (err_valid && prev_valid) check(1'b0, "R3 strobe longer than one cycle", 2, 1);
      if (err_valid) begin
        if (q_err.size() == 0) check(1'b0, "R3 unexpected report", 1, 0);
        else begin
          automatic int e = q_err.pop_front();
          automatic bit re = q_re.pop_front();
          automatic string tg = q_tag.pop_front();
          check(int'(phase_err) == e, tg, int'(phase_err), e);
          check(reinit == re, {tg, " reinit"}, int'(reinit), int'(re));
        end
      end
      prev_valid = err_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired R3 actual=%0d expected=%0d", q_err.size(), 0);
    summary();
    $finish;
  end

  initial begin
    do_reset(1);
    reinit_mode = 1'b0;
    frame(2000,  -10, 1'b1, "R9 first report out of range");
    frame(6000,  20,  1'b1, "R2 R4 leading sync negative");
    frame(10000, 0,   1'b1, "R2 R4 trailing sync positive");
    frame(14000, -1,  1'b1, "R5 same cycle zero");
    frame(18000, -512,1'b1, "R5 adjacent cycle zero");
    frame(22000, 513, 1'b1, "R6 leading 511 in range");
    frame(26000, 512, 1'b1, "R6 R7 trailing 512 out, zero");
    frame(30000, 0,   1'b0, "R6 trailing 511 in range");
    reinit_mode = 1'b1;
    pulse_loc(34000 - 300);
    frame(34000, -5,  1'b1, "R6 R8 missing sync, hold");
    frame(38000, -600,1'b1, "R11 latest leading sync used");
    frame(42000, 0,   1'b0, "R6 R8 aged leading sync, hold");
    reinit_mode = 1'b0;
    frame(42100, 0,   1'b0, "R10 R7 window closed by master");
    frame(46000, 3,   1'b1, "R10 R7 closed window out of range");
    frame(50000, -2,  1'b1, "R2 trailing small");
    frame(54000, 0,   1'b0, "R2 leading small");

    do_reset(3);
    frame(3002,  -2,   1'b1, "R9 first report at div 3");
    frame(7000,  30,   1'b1, "R1 R5 same gate unit zero");
    frame(11000, -1534,1'b1, "R1 trailing at div 3");
    frame(15000, -1540,1'b1, "R1 R6 511 units at div 3");
    frame(19000, 0,    1'b0, "R1 R6 R7 513 units out");
    frame(23000, 0,    1'b0, "R6 R7 missing sync zero");

    do_reset(0);
    reinit_mode = 1'b1;
    frame(1000, -10, 1'b1, "R9 R8 first report hold");
    frame(5000, 0,   1'b0, "R1 div zero acts as one");

    repeat (20) @(negedge clk);
    check(q_err.size() == 0, "R3 every master reported", q_err.size(), 0);
    summary();
    $finish;
  end
endmodule